// File: doc/BRIEF.md
# Three-Level Nested Vectored Interrupt Arbiter

The block gathers a set of peripheral request flags, merges them onto a smaller set of vectors and presents one winning request at a time to a processor. Each vector carries a one-bit level selection. The first vectors (two by default) choose between the lowest and the topmost level. All other vectors choose between the lowest and the middle level. Three levels exist: top above high above low.

The controller keeps one in-service bit per level. A request is raised only when its level is strictly above the highest level now in service, so an interrupt handler can be pre-empted only by a more urgent one. When several vectors qualify, the highest level wins. Between vectors of equal level, the lower vector index (the smaller address) wins.

The vector address and level are registered. They stay frozen from the moment the request line rises until the processor acknowledges it. The acknowledge marks the granted level as in service. A return strobe retires the highest level in service.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset `irq_o` is 0, `vec_addr_o` is 00h, `lvl_o` is 0 and no level is in service.
- R2: A vector is pending when any source mapped to it has both its flag and its enable at 1. A flag whose enable is 0 has no effect. With the default map, sources go to vectors as follows: 0–1 to vector 0, 2–3 to 1, 4–6 to 2, 7–8 to 3, 9 to 4, 10–11 to 5, 12 to 6, 13–14 to 7, 15–18 to 8, 19–20 to 9.
- R3: `lvl_o` encodes low as 1, high as 2 and top as 3. A vector with selection bit 0 is low. With selection bit 1, vectors 0 and 1 are top and all other vectors are high.
- R4: Among pending vectors, the one with the highest level is chosen.
- R5: Among pending vectors of equal level, the lowest vector index is chosen.
- R6: The vector address of index i is 03h + 8·i.
- R7: A request is presented only when its level is strictly greater than the highest level in service. Equal or lower levels wait.
- R8: `irq_o`, `vec_addr_o` and `lvl_o` change one clock after the qualifying condition. While `irq_o` is 1 and no acknowledge arrives, all three hold their values, whatever the inputs do.
- R9: An acknowledge while `irq_o` is 1 marks `lvl_o` as in service and clears `irq_o` on the next clock. An acknowledge while `irq_o` is 0 is ignored.
- R10: A return strobe clears only the highest in-service level. Lower nested levels then become the bar for new requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_flag_i | input | N_SRC | Per-source request flags, held by the source |
| src_en_i | input | N_SRC | Per-source enables |
| lvl_sel_i | input | N_VEC | Per-vector level selection |
| ack_i | input | 1 | Processor accepts the presented request |
| reti_i | input | 1 | Processor returns from the current handler |
| irq_o | output | 1 | Request to the processor |
| vec_addr_o | output | ADDR_W | Address of the presented vector |
| lvl_o | output | 2 | Level of the presented vector |

## Verification
A corrupted in-service bit shows up at the ports within a cycle or two. Either a request at an equal level rises when it should wait, or a legitimate higher request stays silent after a return. Wrong arbitration shows up in the address or level in the very cycle `irq_o` rises. A cycle-accurate behavioural model in the bench tracks the nesting state and compares all three outputs on every clock, across deep nesting and return sequences as well as random traffic.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic [1:0] {
    LV_NONE = 2'd0,
    LV_LOW  = 2'd1,
    LV_HIGH = 2'd2,
    LV_TOP  = 2'd3
  } lvl_e;
endpackage

// File: rtl/nic_vec_merge.sv
module nic_vec_merge #(
  parameter int N_SRC = 21,
  parameter int N_VEC = 10,
  parameter int IDX_W = 4,
  parameter logic [N_SRC*IDX_W-1:0] SRC_MAP = '0
) (
  input  logic [N_SRC-1:0] flag_i,
  input  logic [N_SRC-1:0] en_i,
  output logic [N_VEC-1:0] vec_req_o
);
  logic [N_SRC-1:0] live;
  assign live = flag_i & en_i;

  for (genvar v = 0; v < N_VEC; v++) begin : g_vec
    always_comb begin
      vec_req_o[v] = 1'b0;
      for (int s = 0; s < N_SRC; s++)
        if (SRC_MAP[s*IDX_W +: IDX_W] == IDX_W'(v)) vec_req_o[v] = vec_req_o[v] | live[s];
    end
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int N_VEC     = 10,
  parameter int N_TOP_VEC = 2,
  parameter int IDX_W     = 4
) (
  input  logic [N_VEC-1:0] vec_req_i,
  input  logic [N_VEC-1:0] lvl_sel_i,
  output logic             win_valid_o,
  output logic [IDX_W-1:0] win_idx_o,
  output lvl_e             win_lvl_o
);
  lvl_e vlvl [N_VEC];

  // upper selection differs for the first vectors
  for (genvar v = 0; v < N_VEC; v++) begin : g_lvl
    if (v < N_TOP_VEC) begin : g_top
      assign vlvl[v] = !vec_req_i[v] ? LV_NONE : (lvl_sel_i[v] ? LV_TOP : LV_LOW);
    end else begin : g_mid
      assign vlvl[v] = !vec_req_i[v] ? LV_NONE : (lvl_sel_i[v] ? LV_HIGH : LV_LOW);
    end
  end

  // descending scan with >= leaves the lowest index among equals
  always_comb begin
    win_lvl_o = LV_NONE;
    win_idx_o = '0;
    for (int v = N_VEC - 1; v >= 0; v--) begin
      if (vlvl[v] != LV_NONE && vlvl[v] >= win_lvl_o) begin
        win_lvl_o = vlvl[v];
        win_idx_o = IDX_W'(v);
      end
    end
  end

  assign win_valid_o = (win_lvl_o != LV_NONE);
endmodule

// File: rtl/nic_service.sv
module nic_service
  import nic_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  lvl_e set_lvl_i,
  input  logic clr_i,
  output lvl_e cur_lvl_o
);
  logic [2:0] isr_q;
  logic [2:0] top_bit;
  logic [2:0] set_bit;

  always_comb begin
    top_bit = 3'b000;
    if (isr_q[2])      top_bit = 3'b100;
    else if (isr_q[1]) top_bit = 3'b010;
    else if (isr_q[0]) top_bit = 3'b001;
  end

  always_comb begin
    set_bit = 3'b000;
    if (set_i && set_lvl_i != LV_NONE) set_bit[int'(set_lvl_i) - 1] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= 3'b000;
    else         isr_q <= (clr_i ? (isr_q & ~top_bit) : isr_q) | set_bit;
  end

  always_comb begin
    if (isr_q[2])      cur_lvl_o = LV_TOP;
    else if (isr_q[1]) cur_lvl_o = LV_HIGH;
    else if (isr_q[0]) cur_lvl_o = LV_LOW;
    else               cur_lvl_o = LV_NONE;
  end

  AST_RETI_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i && cur_lvl_o != LV_NONE) |=> cur_lvl_o < $past(cur_lvl_o)); // R10
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int N_SRC     = 21,
  parameter int N_VEC     = 10,
  parameter int N_TOP_VEC = 2,
  parameter int IDX_W     = $clog2(N_VEC),
  parameter logic [N_SRC*IDX_W-1:0] SRC_MAP = 84'h998888776554332221100,
  parameter int ADDR_W    = 8,
  parameter int ADDR_BASE = 3,
  parameter int ADDR_STEP = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_flag_i,
  input  logic [N_SRC-1:0]  src_en_i,
  input  logic [N_VEC-1:0]  lvl_sel_i,
  input  logic              ack_i,
  input  logic              reti_i,
  output logic              irq_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [1:0]        lvl_o
);
  localparam int TOP_ADDR_END = ADDR_BASE + N_TOP_VEC * ADDR_STEP;

  logic [N_VEC-1:0] vec_req;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  lvl_e             win_lvl;
  lvl_e             cur_lvl;
  lvl_e             lvl_q;
  logic             irq_q;
  logic [ADDR_W-1:0] addr_q;
  logic             take;

  nic_vec_merge #(.N_SRC(N_SRC), .N_VEC(N_VEC), .IDX_W(IDX_W), .SRC_MAP(SRC_MAP)) u_merge (
    .flag_i(src_flag_i), .en_i(src_en_i), .vec_req_o(vec_req)
  );

  nic_arbiter #(.N_VEC(N_VEC), .N_TOP_VEC(N_TOP_VEC), .IDX_W(IDX_W)) u_arb (
    .vec_req_i(vec_req), .lvl_sel_i(lvl_sel_i),
    .win_valid_o(win_valid), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  assign take = irq_q && ack_i;

  nic_service u_svc (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(take), .set_lvl_i(lvl_q),
    .clr_i(reti_i), .cur_lvl_o(cur_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      addr_q <= '0;
      lvl_q  <= LV_NONE;
    end else if (irq_q) begin
      if (ack_i) irq_q <= 1'b0;
    end else if (win_valid && win_lvl > cur_lvl) begin
      irq_q  <= 1'b1;
      addr_q <= ADDR_W'(ADDR_BASE + int'(win_idx) * ADDR_STEP);
      lvl_q  <= win_lvl;
    end
  end

  assign irq_o      = irq_q;
  assign vec_addr_o = addr_q;
  assign lvl_o      = lvl_q;

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_addr_o) && $stable(lvl_o))); // R8
  AST_STRICTLY_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (lvl_q > $past(cur_lvl))); // R7
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> !irq_o); // R9
  AST_ACK_IN_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> (cur_lvl == $past(lvl_q))); // R9
  AST_TOP_ONLY_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && lvl_q == LV_TOP) |-> (int'(vec_addr_o) < TOP_ADDR_END)); // R3
  AST_ADDR_GRID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((int'(vec_addr_o) - ADDR_BASE) % ADDR_STEP == 0)); // R6
  AST_LVL_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (lvl_q != LV_NONE)); // R3
endmodule

// File: tb/nest_irq_ctrl_bench.sv
`timescale 1ns/1ps
module nest_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] flags = '0;
  logic [20:0] en = '0;
  logic [9:0]  sel = '0;
  logic        ack = 1'b0;
  logic        reti = 1'b0;
  logic        irq;
  logic [7:0]  vaddr;
  logic [1:0]  lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit m_irq;
  int m_vec, m_lvl;
  bit m_isr [4];

  always #5 clk = ~clk;

  nest_irq_ctrl u_nest_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_flag_i(flags), .src_en_i(en),
    .lvl_sel_i(sel), .ack_i(ack), .reti_i(reti),
    .irq_o(irq), .vec_addr_o(vaddr), .lvl_o(lvl)
  );

  function automatic int src_vec(int s);
    case (s)
      0, 1:             return 0;
      2, 3:             return 1;
      4, 5, 6:          return 2;
      7, 8:             return 3;
      9:                return 4;
      10, 11:           return 5;
      12:               return 6;
      13, 14:           return 7;
      15, 16, 17, 18:   return 8;
      default:          return 9;
    endcase
  endfunction

  task automatic model_edge();
    int cur, best_l, best_v;
    int pl [10];
    bit cleared;
    if (!rst_n) begin
      m_irq = 0; m_vec = 0; m_lvl = 0;
      for (int l = 0; l < 4; l++) m_isr[l] = 0;
      return;
    end
    cur = 0;
    for (int l = 1; l <= 3; l++) if (m_isr[l]) cur = l;
    for (int v = 0; v < 10; v++) pl[v] = 0;
    for (int s = 0; s < 21; s++)
      if (flags[s] && en[s]) begin
        int v = src_vec(s);
        pl[v] = sel[v] ? ((v < 2) ? 3 : 2) : 1;
      end
    best_l = 0; best_v = 0;
    for (int l = 3; l >= 1; l--)
      for (int v = 0; v < 10; v++)
        if (best_l == 0 && pl[v] == l) begin best_l = l; best_v = v; end
    cleared = 0;
    if (reti)
      for (int l = 3; l >= 1; l--)
        if (!cleared && m_isr[l]) begin m_isr[l] = 0; cleared = 1; end
    if (ack && m_irq) m_isr[m_lvl] = 1;
    if (m_irq) begin
      if (ack) m_irq = 0;
    end else if (best_l > cur) begin
      m_irq = 1; m_vec = 3 + 8 * best_v; m_lvl = best_l;
    end
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(irq === m_irq, "R8", "model irq", int'(irq), int'(m_irq));
    check(vaddr === 8'(m_vec), "R6", "model addr", int'(vaddr), m_vec);
    check(lvl === 2'(m_lvl), "R3", "model level", int'(lvl), m_lvl);
  endtask

  task automatic expect_out(bit e_irq, int e_vec, int e_lvl, string tag);
    check(irq === e_irq, tag, "irq", int'(irq), int'(e_irq));
    check(vaddr === 8'(e_vec), tag, "addr", int'(vaddr), e_vec);
    check(lvl === 2'(e_lvl), tag, "level", int'(lvl), e_lvl);
  endtask

  task automatic expect_idle(string tag);
    check(irq === 1'b0, tag, "irq idle", int'(irq), 0);
  endtask

  task automatic pulse_ack();  ack = 1;  step(); ack = 0;  endtask
  task automatic pulse_reti(); reti = 1; step(); reti = 0; endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_edge();
    step(); step();
    expect_out(0, 0, 0, "R1");
    rst_n = 1;
    step();
    expect_out(0, 0, 0, "R1");

    // ack without a request must leave nothing in service
    pulse_ack();
    expect_idle("R9");
    en = '1;
    flags = 21'(1) << 9;
    step();
    expect_out(1, 8'h23, 1, "R2");
    pulse_ack();
    check(irq === 1'b0, "R9", "irq after ack", int'(irq), 0);
    flags = '0;
    pulse_reti();
    step();

    // disabled source ignored
    en = ~(21'(1) << 10);
    flags = 21'(1) << 10;
    step(); step();
    expect_idle("R2");
    flags = '0;
    en = '1;
    step();

    // level beats index
    sel[9] = 1;
    flags = (21'(1) << 20) | (21'(1) << 5);
    step();
    expect_out(1, 8'h4B, 2, "R4");
    flags = '0;
    pulse_ack();                       // high in service
    flags = 21'(1) << 7;               // low on vector 3
    step(); step();
    expect_idle("R7");
    sel[7] = 1;
    flags |= 21'(1) << 13;             // high on vector 7
    step(); step();
    expect_idle("R7");
    sel[0] = 1;
    flags |= 21'(1) << 0;              // top on vector 0
    step();
    expect_out(1, 8'h03, 3, "R7");
    flags &= ~21'(1);
    pulse_ack();                       // top and high in service
    step();
    expect_idle("R9");
    pulse_reti();                      // top retired, high remains
    step();
    expect_idle("R10");
    pulse_reti();                      // high retired
    step();
    expect_out(1, 8'h3B, 2, "R10");
    flags &= ~(21'(1) << 13);
    pulse_ack();
    pulse_reti();
    step();
    expect_out(1, 8'h1B, 1, "R10");

    // tie on level goes to lowest index, then hold while waiting
    pulse_ack();
    flags = '0;
    pulse_reti();
    step();
    sel[3] = 1; sel[6] = 1;
    flags = (21'(1) << 8) | (21'(1) << 12);
    step();
    expect_out(1, 8'h1B, 2, "R5");
    flags |= 21'(1) << 1;
    step(); step();
    expect_out(1, 8'h1B, 2, "R8");
    pulse_ack();
    step();
    expect_out(1, 8'h03, 3, "R4");
    pulse_ack();
    pulse_reti();
    pulse_reti();
    flags = '0;
    step();

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      for (int s = 0; s < 21; s++) if (($urandom % 16) == 0) flags[s] = ~flags[s];
      if (($urandom % 8) == 0) en = 21'($urandom) | 21'($urandom);
      if (($urandom % 32) == 0) sel = 10'($urandom);
      ack  = (($urandom % 4) == 0);
      reti = (($urandom % 6) == 0);
      step();
    end
    ack = 0; reti = 0;
    finish_run();
  end
endmodule